// File: doc/BRIEF.md
# Time-Shared Serial FIR Filter

This block is a 25-tap finite impulse response filter for slow sample streams such as audio, placed in a design whose clock runs far faster than its sample rate. One adder-based multiplier and one sum register serve every tap. Each accepted input sample goes into a small circular buffer. A controller then visits the taps one after another. For each tap it fetches a stored sample and its coefficient, forms their product over sixteen shift-and-add clocks, and adds the product into a running sum. When the last tap has been added, the sum is scaled, clamped to the output width and presented for one clock.

Coefficients are written through a simple write port: an enable, a tap index and a value. The caller keeps one strobe per sample. A strobe that arrives while the filter is still working on the previous sample is refused, and a one-clock overrun flag reports it.

Top module: `fir_serial`

## Requirements
- R1: While reset is held and in the first cycle after it, `resultOut` is 0, `resultValid` is 0 and `overrun` is 0. The sample history and all coefficients start at zero.
- R2: For each accepted sample n, the output is y[n] = (sum over k = 0..24 of c[k]·x[n−k]) arithmetically shifted right by 15. All values are signed two's complement. Here c[k] is the coefficient at tap index k, and x[n−k] is the sample accepted k strobes earlier (zero if no such sample has been accepted since reset).
- R3: When the shifted sum is above 32767, the output is 32767 (0x7FFF). When it is below −32768, the output is −32768 (0x8000).
- R4: `resultValid` is high for exactly one clock per accepted sample. `resultOut` changes only in a cycle where `resultValid` is high, and it holds its value otherwise.
- R5: A `sampleValid` strobe that arrives while a computation is in progress raises `overrun` for one clock, starting in the cycle after the strobe. That sample never enters the history and produces no output.
- R6: A coefficient write with `coefWrEn` high stores `coefData` as c[`coefAddr`]. A write whose `coefAddr` is 25 or higher changes nothing.
- R7: `resultValid` rises exactly 451 clocks after the clock edge that accepts the sample, which is 25·(16+2)+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-clock strobe marking a new input sample |
| sampleIn | input | 16 | Signed input sample |
| coefWrEn | input | 1 | Coefficient write enable |
| coefAddr | input | 5 | Tap index of the coefficient written |
| coefData | input | 16 | Signed coefficient value |
| resultOut | output | 16 | Signed, scaled and saturated filter output |
| resultValid | output | 1 | One-clock strobe, new output present |
| overrun | output | 1 | One-clock flag, a strobe arrived while busy |

## Verification
The hardest case to reach from the ports is a strobe that lands in the middle of a computation. Producing one requires a second strobe to be timed against the 451-clock schedule while a sum is only partly built. The bench counts clocks after each accepted sample and fires an extra strobe carrying a distinct sample part way through the tap walk. It then checks that the overrun flag rises and that the following outputs still match a history without that sample. Both saturation limits are reached by filling the history with full-scale samples of one sign against full-scale coefficients.

// File: rtl/fir_serial_pkg.sv
package fir_serial_pkg;

  // Strobes from the sequencer to the datapath; at most one step strobe per cycle.
  typedef struct packed {
    logic writeSample;
    logic clearAcc;
    logic loadOps;
    logic mulStep;
    logic lastBit;
    logic accumulate;
    logic finish;
  } firCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MUL,
    ST_ACC,
    ST_DONE
  } firState_t;

endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_serial_pkg::*;
#(
  parameter int TAPS = 25,
  parameter int CW   = 16,
  localparam int AW  = $clog2(TAPS),
  localparam int BW  = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  output firCtrl_t      ctl,
  output logic [AW-1:0] smpAddr,
  output logic [AW-1:0] coefIdx,
  output logic          overrun
);

  localparam logic [AW-1:0] LAST_TAP = AW'(TAPS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(CW - 1);

  firState_t     state;
  logic [AW-1:0] head;
  logic [AW-1:0] headNext;
  logic [AW-1:0] tap;
  logic [BW-1:0] bitCnt;
  logic [AW:0]   wrapSum;

  assign headNext = (head == LAST_TAP) ? '0 : head + 1'b1;
  assign wrapSum  = {1'b0, head} + (AW+1)'(TAPS) - {1'b0, tap};
  assign coefIdx  = tap;

  always_comb begin
    if (state == ST_IDLE)
      smpAddr = headNext;
    else if (head >= tap)
      smpAddr = head - tap;
    else
      smpAddr = wrapSum[AW-1:0];
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        ctl.writeSample = sampleValid;
        ctl.clearAcc    = sampleValid;
      end
      ST_LOAD: ctl.loadOps = 1'b1;
      ST_MUL: begin
        ctl.mulStep = 1'b1;
        ctl.lastBit = (bitCnt == LAST_BIT);
      end
      ST_ACC:  ctl.accumulate = 1'b1;
      ST_DONE: ctl.finish = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      head    <= LAST_TAP;
      tap     <= '0;
      bitCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= sampleValid && (state != ST_IDLE);
      unique case (state)
        ST_IDLE: if (sampleValid) begin
          head  <= headNext;
          tap   <= '0;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          bitCnt <= '0;
          state  <= ST_MUL;
        end
        ST_MUL: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ST_ACC;
        end
        ST_ACC: begin
          if (tap == LAST_TAP) state <= ST_DONE;
          else begin
            tap   <= tap + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_serial_pkg::*;
#(
  parameter int TAPS = 25,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int AW  = $clog2(TAPS),
  localparam int PW  = DW + CW,
  localparam int ACCW = PW + AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  firCtrl_t      ctl,
  input  logic [AW-1:0] smpAddr,
  input  logic [AW-1:0] coefIdx,
  input  logic [DW-1:0] sampleIn,
  input  logic          coefWrEn,
  input  logic [AW-1:0] coefAddr,
  input  logic [CW-1:0] coefData,
  output logic [DW-1:0] resultOut,
  output logic          resultValid
);

  localparam logic signed [ACCW-1:0] MAXV = ACCW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;

  logic [DW-1:0] delayMem [TAPS];
  logic [CW-1:0] coefMem  [TAPS];

  logic signed [PW-1:0]   mcand;
  logic signed [PW-1:0]   prod;
  logic [CW-1:0]          mplier;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] scaled;
  logic [DW-1:0]          satVal;
  logic [DW-1:0]          rdSample;

  assign rdSample = delayMem[smpAddr];

  // One storage slot per tap for samples and coefficients.
  for (genvar i = 0; i < TAPS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        delayMem[i] <= '0;
        coefMem[i]  <= '0;
      end else begin
        if (ctl.writeSample && smpAddr == AW'(i)) delayMem[i] <= sampleIn;
        if (coefWrEn && coefAddr == AW'(i))       coefMem[i]  <= coefData;
      end
    end
  end

  // Shift-and-add multiplier; the top multiplier bit carries negative weight.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcand  <= '0;
      prod   <= '0;
      mplier <= '0;
    end else if (ctl.loadOps) begin
      mcand  <= {{CW{rdSample[DW-1]}}, rdSample};
      mplier <= coefMem[coefIdx];
      prod   <= '0;
    end else if (ctl.mulStep) begin
      if (mplier[0]) prod <= ctl.lastBit ? prod - mcand : prod + mcand;
      mcand  <= mcand <<< 1;
      mplier <= mplier >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) acc <= '0;
    else if (ctl.clearAcc) acc <= '0;
    else if (ctl.accumulate) acc <= acc + {{AW{prod[PW-1]}}, prod};
  end

  assign scaled = acc >>> (CW - 1);

  always_comb begin
    if (scaled > MAXV)      satVal = {1'b0, {(DW-1){1'b1}}};
    else if (scaled < MINV) satVal = {1'b1, {(DW-1){1'b0}}};
    else                    satVal = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctl.finish;
      if (ctl.finish) resultOut <= satVal;
    end
  end

endmodule

// File: rtl/fir_serial.sv
module fir_serial
  import fir_serial_pkg::*;
#(
  parameter int TAPS = 25,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int AW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleIn,
  input  logic          coefWrEn,
  input  logic [AW-1:0] coefAddr,
  input  logic [CW-1:0] coefData,
  output logic [DW-1:0] resultOut,
  output logic          resultValid,
  output logic          overrun
);

  firCtrl_t      ctl;
  logic [AW-1:0] smpAddr;
  logic [AW-1:0] coefIdx;

  fir_ctrl #(.TAPS(TAPS), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ctl        (ctl),
    .smpAddr    (smpAddr),
    .coefIdx    (coefIdx),
    .overrun    (overrun)
  );

  fir_datapath #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .smpAddr    (smpAddr),
    .coefIdx    (coefIdx),
    .sampleIn   (sampleIn),
    .coefWrEn   (coefWrEn),
    .coefAddr   (coefAddr),
    .coefData   (coefData),
    .resultOut  (resultOut),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/fir_serial_chk.sv
module fir_serial_chk
  import fir_serial_pkg::*;
#(
  parameter int TAPS = 25,
  parameter int DW   = 16,
  localparam int AW  = $clog2(TAPS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          sampleValid,
  input logic [DW-1:0] resultOut,
  input logic          resultValid,
  input logic          overrun,
  input firCtrl_t      ctl,
  input logic [AW-1:0] smpAddr,
  input logic [AW-1:0] coefIdx
);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultOut));

  // R4
  finish_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> resultValid);

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(sampleValid));

  // R5
  refused_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !ctl.writeSample) |=> overrun);

  // R7
  accept_to_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeSample |=> ctl.loadOps);

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.writeSample, ctl.loadOps, ctl.mulStep, ctl.accumulate, ctl.finish}));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, smpAddr} < (AW+1)'(TAPS)) && ({1'b0, coefIdx} < (AW+1)'(TAPS)));

endmodule

bind fir_serial fir_serial_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .resultOut  (resultOut),
  .resultValid(resultValid),
  .overrun    (overrun),
  .ctl        (ctl),
  .smpAddr    (smpAddr),
  .coefIdx    (coefIdx)
);

// File: tb/fir_serial_tb.sv
module fir_serial_tb;

  localparam int TAPS = 25;
  localparam int LAT  = TAPS * (16 + 2) + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        coefWrEn = 1'b0;
  logic [4:0]  coefAddr = '0;
  logic [15:0] coefData = '0;
  logic [15:0] resultOut;
  logic        resultValid;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  longint coefM [TAPS];
  longint hist  [TAPS];
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  fir_serial u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .coefWrEn(coefWrEn), .coefAddr(coefAddr), .coefData(coefData),
    .resultOut(resultOut), .resultValid(resultValid), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[30:15];
  endfunction

  function automatic longint expected();
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += coefM[k] * hist[k];
    s = s >>> 15;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic writeCoef(input int addr, input logic [15:0] val);
    @(negedge clk);
    coefWrEn = 1'b1; coefAddr = 5'(addr); coefData = val;
    @(negedge clk);
    coefWrEn = 1'b0;
    // R6: indices at or above the tap count have no effect
    if (addr < TAPS) coefM[addr] = longint'($signed(val));
  endtask

  task automatic runSample(input logic [15:0] v, input bit doOv, input string req);
    int cnt = 0;
    longint exp;
    logic [15:0] held;
    @(negedge clk);
    sampleValid = 1'b1; sampleIn = v;
    @(negedge clk);
    sampleValid = 1'b0;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(v));
    exp = expected();
    while (1) begin
      @(negedge clk);
      cnt++;
      if (doOv && cnt == 5) begin
        sampleValid = 1'b1; sampleIn = 16'h4D2C;
      end
      if (doOv && cnt == 6) begin
        sampleValid = 1'b0;
        // R5 flag raised one cycle after the refused strobe
        check(overrun === 1'b1, "R5", longint'(overrun), 1);
      end
      if (doOv && cnt == 7) check(overrun === 1'b0, "R5", longint'(overrun), 0);
      if (resultValid === 1'b1) break;
      if (cnt > 2 * LAT) begin
        check(1'b0, "R7", cnt, LAT);
        return;
      end
    end
    // R7 fixed latency
    check(cnt == LAT, "R7", cnt, LAT);
    check($signed(resultOut) == exp, req, longint'($signed(resultOut)), exp);
    held = resultOut;
    @(negedge clk);
    // R4 one-clock strobe, value held
    check(resultValid === 1'b0, "R4", longint'(resultValid), 0);
    check(resultOut === held, "R4", longint'(resultOut), longint'(held));
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin coefM[k] = 0; hist[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 outputs while in reset
    check(resultOut === 16'h0, "R1", longint'(resultOut), 0);
    check(resultValid === 1'b0, "R1", longint'(resultValid), 0);
    check(overrun === 1'b0, "R1", longint'(overrun), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resultValid === 1'b0 && resultOut === 16'h0, "R1", longint'(resultOut), 0);
    check(overrun === 1'b0, "R1", longint'(overrun), 0);

    // R1: zero coefficients after reset give zero output
    runSample(16'h7FFF, 1'b0, "R1");

    // R2/R6: ramp coefficients, impulse walks across every tap index
    for (int k = 0; k < TAPS; k++) writeCoef(k, 16'(k * 1000 - 12000));
    runSample(16'h4000, 1'b0, "R2");
    for (int n = 0; n < TAPS; n++) runSample(16'h0000, 1'b0, "R2");

    // R2: pseudo-random coefficients and samples, both signs
    for (int k = 0; k < TAPS; k++) writeCoef(k, 16'($signed(nextRand()) >>> 2));
    for (int n = 0; n < 30; n++) runSample(nextRand(), 1'b0, "R2");

    // R5: extra strobes mid-computation are refused
    for (int n = 0; n < 5; n++) runSample(nextRand(), 1'b1, "R5");

    // R6: writes above the last tap index change nothing
    for (int a = TAPS; a < 32; a++) writeCoef(a, 16'h7FFF);
    for (int n = 0; n < 8; n++) runSample(nextRand(), 1'b0, "R6");

    // R3: full-scale history against full-scale coefficients
    for (int k = 0; k < TAPS; k++) writeCoef(k, 16'h7FFF);
    for (int n = 0; n < 12; n++) runSample(16'h7FFF, 1'b0, "R3");
    for (int n = 0; n < 14; n++) runSample(16'h8000, 1'b0, "R3");
    for (int k = 0; k < TAPS; k++) writeCoef(k, 16'h8000);
    runSample(16'h8000, 1'b0, "R3");
    for (int n = 0; n < TAPS; n++) runSample(16'h7FFF, 1'b0, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule